// File: doc/BRIEF.md
# Serial Peripheral Register Bank with Atomic Bit Aliases

This block is the software-visible register file of a serial peripheral. A word-addressed read/write bus reaches a control register, a status register, a data-buffer port, a baud-divider register and a second control register. The control, status and second control registers each own three extra write-only words that clear, set or toggle only the bits written as one. Software can therefore change single bits without a read-modify-write sequence that a concurrent hardware update could break.

The status register combines software-clearable sticky fault flags with live values from hardware: both FIFO fill levels and a receive-empty flag. A read of the data port takes one word from the receive FIFO and pops it. A write to the data port pushes the word into the transmit FIFO. The serial engine and both FIFOs live outside the block and connect through ports. A fault interrupt is formed from the sticky flags and their enables in the second control register.

Every bus request is answered exactly one cycle later with a registered response.

Top module: `serial_reg_bank`

## Requirements
- R1: After reset the control, second control, baud and sticky status bits are zero, `busRvalid` is low, `faultIrq` is low, and no pop or push strobe is active.
- R2: A plain write to word 0 (control) or word 16 (second control) stores all 32 bits, and a later read returns them. `busRvalid` is high in the cycle after each request, with `busRdata` valid in that cycle. A write response carries zero.
- R3: A write to a clear alias clears every bit written as one and leaves the other bits unchanged. The clear aliases are word 1 for control, word 5 for status and word 17 for second control.
- R4: A write to a set alias sets every bit written as one and leaves the other bits unchanged. The set aliases are word 2 for control, word 6 for status and word 18 for second control.
- R5: A write to an invert alias toggles every bit written as one and leaves the other bits unchanged. The invert aliases are word 3 for control, word 7 for status and word 19 for second control. Reads of any alias word return zero.
- R6: Word 12 holds a 9-bit baud divider. A write stores bits 8:0 of the data, and a read returns them with bits 31:9 as zero.
- R7: A read of word 4 returns live values in three fields: the transmit FIFO level in bits 20:16, the receive FIFO level in bits 28:24, and the receive-empty flag in bit 5. Writes cannot change these fields. Only bits 6, 8 and 12 of status are storable, and all other bits read as zero.
- R8: Three hardware event inputs set three sticky status flags: receive overflow sets bit 6, transmit underrun sets bit 8 and frame error sets bit 12. A flag stays set until software clears it through a status write. An event arriving in the same cycle as a clearing write leaves its flag set.
- R9: `faultIrq` is the OR of three terms, each a flag AND its enable in second control: bit 8 with enable bit 10, bit 6 with enable bit 11, and bit 12 with enable bit 12. It follows a register change in the next cycle.
- R10: A read of word 8 with the receive FIFO non-empty raises `rxPop` in the request cycle only and returns `rxData`. With the FIFO empty it raises no pop and returns zero.
- R11: A write to word 8 raises `txPush` in the request cycle with `txData` equal to the written word. No other word produces a push.
- R12: Writes to reserved words (9 to 11, 13 to 15, 20 to 31) change no register, and reads of them return zero.
- R13: `periphOn` follows control bit 15 and `masterSel` follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus request valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Response data |
| busRvalid | output | 1 | Response valid, one cycle after request |
| txLevel | input | 5 | Transmit FIFO fill level |
| rxLevel | input | 5 | Receive FIFO fill level |
| rxEmpty | input | 1 | Receive FIFO empty |
| rxData | input | 32 | Receive FIFO head word |
| rxPop | output | 1 | Pop strobe to receive FIFO |
| txPush | output | 1 | Push strobe to transmit FIFO |
| txData | output | 32 | Word to push |
| rovEvt | input | 1 | Receive overflow event |
| turEvt | input | 1 | Transmit underrun event |
| ferrEvt | input | 1 | Frame error event |
| ctrlOut | output | 32 | Control register value |
| ctrl2Out | output | 32 | Second control register value |
| baudOut | output | 9 | Baud divider value |
| periphOn | output | 1 | Peripheral enable |
| masterSel | output | 1 | Master mode select |
| faultIrq | output | 1 | Fault interrupt request |

## Verification
The hardest case to reach from the ports is a hardware fault event that lands in the same clock cycle as a software write clearing the same status flag. The write may be a clear alias, a plain write or a toggle, and the outcome depends on which update takes priority. The bench's bus task takes an event vector and drives the event inputs in the exact cycle that carries the write. It then reads status back to confirm the flag survived. A second delicate case is a data-port read against an empty FIFO: the bench switches `rxEmpty` between requests and checks both the pop strobe and the zero response.

// File: rtl/srb_pkg.sv
package srb_pkg;

  localparam int REG_W = 32;

  // word addresses whose position software depends on
  localparam int W_CTRL  = 0;
  localparam int W_STAT  = 4;
  localparam int W_DATA  = 8;
  localparam int W_BAUD  = 12;
  localparam int W_CTRL2 = 16;

  // bit positions decoded by neighbours
  localparam int CTRL_ON_BIT     = 15;
  localparam int CTRL_MASTER_BIT = 5;
  localparam int STAT_EMPTY_BIT  = 5;
  localparam int STAT_ROV_BIT    = 6;
  localparam int STAT_TUR_BIT    = 8;
  localparam int STAT_FERR_BIT   = 12;
  localparam int STAT_TXLVL_LSB  = 16;
  localparam int STAT_RXLVL_LSB  = 24;
  localparam int C2_TUR_EN_BIT   = 10;
  localparam int C2_ROV_EN_BIT   = 11;
  localparam int C2_FERR_EN_BIT  = 12;

  localparam logic [REG_W-1:0] STAT_SW_MASK =
    (REG_W'(1) << STAT_ROV_BIT) | (REG_W'(1) << STAT_TUR_BIT) |
    (REG_W'(1) << STAT_FERR_BIT);

  typedef enum logic [2:0] {
    TGT_NONE, TGT_CTRL, TGT_STAT, TGT_DATA, TGT_BAUD, TGT_CTRL2
  } tgt_e;

  // order matches the word offset inside an aliased group
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0, OP_CLR = 2'd1, OP_SET = 2'd2, OP_INV = 2'd3
  } op_e;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
    tgt_e tgt;
    op_e  op;
  } strobe_t;

  function automatic logic [REG_W-1:0] applyOp(
    input logic [REG_W-1:0] oldVal,
    input logic [REG_W-1:0] wd,
    input op_e op
  );
    case (op)
      OP_CLR:  applyOp = oldVal & ~wd;
      OP_SET:  applyOp = oldVal | wd;
      OP_INV:  applyOp = oldVal ^ wd;
      default: applyOp = wd;
    endcase
  endfunction

endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);

  logic [ADDR_W-1:0] wordBase;
  logic [1:0]        wordOff;

  assign wordBase = {busAddr[ADDR_W-1:2], 2'b00};
  assign wordOff  = busAddr[1:0];

  always_comb begin
    stb.wrStb = busSel & busWr;
    stb.rdStb = busSel & ~busWr;
    stb.op    = op_e'(wordOff);
    stb.tgt   = TGT_NONE;
    if (wordBase == ADDR_W'(W_CTRL)) begin
      stb.tgt = TGT_CTRL;
    end else if (wordBase == ADDR_W'(W_STAT)) begin
      stb.tgt = TGT_STAT;
    end else if (wordBase == ADDR_W'(W_CTRL2)) begin
      stb.tgt = TGT_CTRL2;
    end else if (busAddr == ADDR_W'(W_DATA)) begin
      stb.tgt = TGT_DATA;
      stb.op  = OP_WRITE;
    end else if (busAddr == ADDR_W'(W_BAUD)) begin
      stb.tgt = TGT_BAUD;
      stb.op  = OP_WRITE;
    end
  end

endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
#(
  parameter int BAUD_W = 9,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              busRvalid,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              rxEmpty,
  input  logic [REG_W-1:0]  rxData,
  output logic              rxPop,
  output logic              txPush,
  output logic [REG_W-1:0]  txData,
  input  logic              rovEvt,
  input  logic              turEvt,
  input  logic              ferrEvt,
  output logic [REG_W-1:0]  ctrlOut,
  output logic [REG_W-1:0]  ctrl2Out,
  output logic [BAUD_W-1:0] baudOut,
  output logic              periphOn,
  output logic              masterSel,
  output logic              faultIrq
);

  localparam int NREG = 3;  // 0 control, 1 status, 2 second control

  logic [REG_W-1:0]  regVal [NREG];
  logic [REG_W-1:0]  hwSetW [NREG];
  logic [BAUD_W-1:0] baudQ;
  logic [REG_W-1:0]  statView;
  logic [REG_W-1:0]  rdNext;
  logic [REG_W-1:0]  rdataQ;
  logic              rvalidQ;

  always_comb begin
    hwSetW[0] = '0;
    hwSetW[1] = '0;
    hwSetW[1][STAT_ROV_BIT]  = rovEvt;
    hwSetW[1][STAT_TUR_BIT]  = turEvt;
    hwSetW[1][STAT_FERR_BIT] = ferrEvt;
    hwSetW[2] = '0;
  end

  // aliased registers: one instance of the same update path each
  for (genvar g = 0; g < NREG; g++) begin : g_areg
    localparam tgt_e MY_TGT = (g == 0) ? TGT_CTRL : (g == 1) ? TGT_STAT : TGT_CTRL2;
    localparam logic [REG_W-1:0] MY_MASK = (g == 1) ? STAT_SW_MASK : '1;
    logic             hit;
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] nxt;

    assign hit = stb.wrStb && (stb.tgt == MY_TGT);

    always_comb begin
      nxt = hit ? applyOp(q, busWdata, stb.op) : q;
      nxt = (nxt | hwSetW[g]) & MY_MASK;  // hardware set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign regVal[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baudQ <= '0;
    end else if (stb.wrStb && stb.tgt == TGT_BAUD) begin
      baudQ <= busWdata[BAUD_W-1:0];
    end
  end

  always_comb begin
    statView = regVal[1];
    statView[STAT_EMPTY_BIT] = rxEmpty;
    statView[STAT_TXLVL_LSB +: LVL_W] = txLevel;
    statView[STAT_RXLVL_LSB +: LVL_W] = rxLevel;
  end

  always_comb begin
    rdNext = '0;
    case (stb.tgt)
      TGT_CTRL:  if (stb.op == OP_WRITE) rdNext = regVal[0];
      TGT_STAT:  if (stb.op == OP_WRITE) rdNext = statView;
      TGT_CTRL2: if (stb.op == OP_WRITE) rdNext = regVal[2];
      TGT_DATA:  if (!rxEmpty) rdNext = rxData;
      TGT_BAUD:  rdNext = REG_W'(baudQ);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdataQ  <= '0;
      rvalidQ <= 1'b0;
    end else begin
      rdataQ  <= stb.rdStb ? rdNext : '0;
      rvalidQ <= stb.wrStb | stb.rdStb;
    end
  end

  assign busRdata  = rdataQ;
  assign busRvalid = rvalidQ;
  assign rxPop     = stb.rdStb && (stb.tgt == TGT_DATA) && !rxEmpty;
  assign txPush    = stb.wrStb && (stb.tgt == TGT_DATA);
  assign txData    = busWdata;
  assign ctrlOut   = regVal[0];
  assign ctrl2Out  = regVal[2];
  assign baudOut   = baudQ;
  assign periphOn  = regVal[0][CTRL_ON_BIT];
  assign masterSel = regVal[0][CTRL_MASTER_BIT];
  assign faultIrq  = (regVal[1][STAT_TUR_BIT]  & regVal[2][C2_TUR_EN_BIT]) |
                     (regVal[1][STAT_ROV_BIT]  & regVal[2][C2_ROV_EN_BIT]) |
                     (regVal[1][STAT_FERR_BIT] & regVal[2][C2_FERR_EN_BIT]);

  // ---------------- assertions ----------------
  p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrStb || stb.rdStb) |=> busRvalid);

  p_clear_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrStb && stb.tgt == TGT_CTRL && stb.op == OP_CLR) |=>
      ((ctrlOut & $past(busWdata)) == '0));

  p_set_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrStb && stb.tgt == TGT_CTRL2 && stb.op == OP_SET) |=>
      ((ctrl2Out & $past(busWdata)) == $past(busWdata)));

  p_toggle_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrStb && stb.tgt == TGT_CTRL && stb.op == OP_INV) |=>
      (ctrlOut == $past(ctrlOut ^ busWdata)));

  p_baud_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdStb && stb.tgt == TGT_BAUD) |=> (busRdata[REG_W-1:BAUD_W] == '0));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (regVal[1][STAT_ROV_BIT] && !(stb.wrStb && stb.tgt == TGT_STAT)) |=>
      regVal[1][STAT_ROV_BIT]);

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rovEvt |=> regVal[1][STAT_ROV_BIT]);

  p_empty_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdStb && stb.tgt == TGT_DATA && rxEmpty) |=> (busRdata == '0));

  p_reserved_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrStb && stb.tgt == TGT_NONE) |=>
      ($stable(ctrlOut) && $stable(ctrl2Out) && $stable(baudOut)));

endmodule

// File: rtl/serial_reg_bank.sv
module serial_reg_bank
  import srb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BAUD_W = 9,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              rxEmpty,
  input  logic [31:0]       rxData,
  output logic              rxPop,
  output logic              txPush,
  output logic [31:0]       txData,
  input  logic              rovEvt,
  input  logic              turEvt,
  input  logic              ferrEvt,
  output logic [31:0]       ctrlOut,
  output logic [31:0]       ctrl2Out,
  output logic [BAUD_W-1:0] baudOut,
  output logic              periphOn,
  output logic              masterSel,
  output logic              faultIrq
);

  strobe_t stb;

  srb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  srb_datapath #(.BAUD_W(BAUD_W), .LVL_W(LVL_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .busRvalid (busRvalid),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .rxEmpty   (rxEmpty),
    .rxData    (rxData),
    .rxPop     (rxPop),
    .txPush    (txPush),
    .txData    (txData),
    .rovEvt    (rovEvt),
    .turEvt    (turEvt),
    .ferrEvt   (ferrEvt),
    .ctrlOut   (ctrlOut),
    .ctrl2Out  (ctrl2Out),
    .baudOut   (baudOut),
    .periphOn  (periphOn),
    .masterSel (masterSel),
    .faultIrq  (faultIrq)
  );

  p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busSel |=> !busRvalid);

endmodule

// File: tb/tb_serial_reg_bank.sv
module tb_serial_reg_bank;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [4:0]  txLevel = '0, rxLevel = '0;
  logic        rxEmpty = 1'b1;
  logic [31:0] rxData = '0;
  logic        rxPop, txPush;
  logic [31:0] txData;
  logic        rovEvt = 1'b0, turEvt = 1'b0, ferrEvt = 1'b0;
  logic [31:0] ctrlOut, ctrl2Out;
  logic [8:0]  baudOut;
  logic        periphOn, masterSel, faultIrq;

  int nChecks = 0;
  int nBad = 0;
  bit started = 1'b0;

  // bench model
  logic [31:0] mCtrl = '0, mStat = '0, mC2 = '0;
  logic [8:0]  mBaud = '0;

  logic [31:0] expData[$];
  string       expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxEmpty(rxEmpty), .rxData(rxData), .rxPop(rxPop), .txPush(txPush),
    .txData(txData), .rovEvt(rovEvt), .turEvt(turEvt), .ferrEvt(ferrEvt),
    .ctrlOut(ctrlOut), .ctrl2Out(ctrl2Out), .baudOut(baudOut),
    .periphOn(periphOn), .masterSel(masterSel), .faultIrq(faultIrq)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] applyM(input logic [31:0] o,
                                         input logic [31:0] w,
                                         input logic [1:0] off);
    case (off)
      2'd1: applyM = o & ~w;
      2'd2: applyM = o | w;
      2'd3: applyM = o ^ w;
      default: applyM = w;
    endcase
  endfunction

  function automatic logic [31:0] statView();
    return mStat | ({27'b0, rxLevel} << 24) | ({27'b0, txLevel} << 16) |
           ({31'b0, rxEmpty} << 5);
  endfunction

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    case (a)
      5'd0:  return mCtrl;
      5'd4:  return statView();
      5'd16: return mC2;
      5'd12: return {23'b0, mBaud};
      5'd8:  return rxEmpty ? 32'h0 : rxData;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expIrq();
    return (mStat[8] & mC2[10]) | (mStat[6] & mC2[11]) | (mStat[12] & mC2[12]);
  endfunction

  // driver: one request, expected response queued for the monitor
  task automatic busOp(input logic wr, input logic [4:0] addr,
                       input logic [31:0] wd, input logic [2:0] evt,
                       input string tag);
    logic expPop, expPush;
    @(negedge clk);
    expData.push_back(wr ? 32'h0 : modelRead(addr));
    expTag.push_back(tag);
    expPop  = !wr && addr == 5'd8 && !rxEmpty;
    expPush = wr && addr == 5'd8;
    busSel = 1'b1; busWr = wr; busAddr = addr; busWdata = wd;
    {ferrEvt, turEvt, rovEvt} = evt;
    #1;
    chk(rxPop === expPop, {tag, " R10 pop"}, 32'(rxPop), 32'(expPop));
    chk(txPush === expPush, {tag, " R11 push"}, 32'(txPush), 32'(expPush));
    if (expPush) chk(txData === wd, {tag, " R11 data"}, txData, wd);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    {ferrEvt, turEvt, rovEvt} = 3'b000;
    if (wr) begin
      case ({addr[4:2], 2'b00})
        5'd0:  mCtrl = applyM(mCtrl, wd, addr[1:0]);
        5'd4:  mStat = applyM(mStat, wd, addr[1:0]) & 32'h0000_1140;
        5'd16: mC2   = applyM(mC2, wd, addr[1:0]);
        default: ;
      endcase
      if (addr == 5'd12) mBaud = wd[8:0];
    end
    if (evt[0]) mStat[6]  = 1'b1;
    if (evt[1]) mStat[8]  = 1'b1;
    if (evt[2]) mStat[12] = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    busOp(1'b1, a, d, 3'b000, tag);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    busOp(1'b0, a, 32'h0, 3'b000, tag);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  // monitor: scoreboard compare of every response
  always @(negedge clk) begin
    if (started && busRvalid) begin
      if (expData.size() == 0) begin
        chk(1'b0, "R2 unexpected response", busRdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expData.pop_front();
        t = expTag.pop_front();
        chk(busRdata === e, t, busRdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busRvalid === 1'b0, "R1 rvalid in reset", 32'(busRvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrlOut === 0, "R1 ctrl reset", ctrlOut, 0);
    chk(ctrl2Out === 0, "R1 ctrl2 reset", ctrl2Out, 0);
    chk(baudOut === 0, "R1 baud reset", 32'(baudOut), 0);
    chk(faultIrq === 0, "R1 irq reset", 32'(faultIrq), 0);
    chk(rxPop === 0 && txPush === 0, "R1 strobes reset", 32'({rxPop, txPush}), 0);
    started = 1'b1;
    rd(5'd0, "R1 ctrl read");
    rd(5'd4, "R1 status read");
    rd(5'd16, "R1 ctrl2 read");

    wr(5'd0, 32'h0000_8020, "R2 ctrl write");
    rd(5'd0, "R2 ctrl readback");
    chk(periphOn === 1 && masterSel === 1, "R13 on+master", 32'({periphOn, masterSel}), 3);
    wr(5'd16, 32'hA5A5_0F0F, "R2 ctrl2 write");
    rd(5'd16, "R2 ctrl2 readback");

    wr(5'd1, 32'h0000_0020, "R3 ctrl clear");
    rd(5'd0, "R3 ctrl after clear");
    chk(masterSel === 0 && periphOn === 1, "R13 master cleared", 32'({periphOn, masterSel}), 2);
    wr(5'd17, 32'hFF00_00FF, "R3 ctrl2 clear");
    rd(5'd16, "R3 ctrl2 after clear");

    wr(5'd2, 32'h00F0_0003, "R4 ctrl set");
    rd(5'd0, "R4 ctrl after set");
    wr(5'd18, 32'h0000_1C00, "R4 ctrl2 set enables");
    rd(5'd16, "R4 ctrl2 after set");

    wr(5'd3, 32'hFFFF_0000, "R5 ctrl invert");
    rd(5'd0, "R5 ctrl after invert");
    chk(periphOn === mCtrl[15], "R13 on after invert", 32'(periphOn), 32'(mCtrl[15]));
    wr(5'd19, 32'h0000_0C00, "R5 ctrl2 invert");
    rd(5'd16, "R5 ctrl2 after invert");
    wr(5'd19, 32'h0000_0C00, "R5 ctrl2 invert back");
    rd(5'd3, "R5 alias read zero");
    rd(5'd18, "R5 alias read zero");

    wr(5'd12, 32'hFFFF_FFFF, "R6 baud write");
    rd(5'd12, "R6 baud read");
    chk(baudOut === 9'h1FF, "R6 baud out", 32'(baudOut), 32'h1FF);

    txLevel = 5'd7; rxLevel = 5'd19; rxEmpty = 1'b0; rxData = 32'hDEAD_BEEF;
    rd(5'd4, "R7 status live fields");
    wr(5'd4, 32'hFFFF_FFFF, "R7 status write all");
    rd(5'd4, "R7 status after write");
    chk(faultIrq === expIrq(), "R9 irq from sw set", 32'(faultIrq), 32'(expIrq()));
    wr(5'd5, 32'hFFFF_FFFF, "R3 status clear all");
    rd(5'd4, "R3 status after clear");
    chk(faultIrq === 0, "R9 irq cleared", 32'(faultIrq), 0);

    busOp(1'b0, 5'd0, 32'h0, 3'b001, "R8 overflow event");
    chk(faultIrq === expIrq(), "R9 irq overflow", 32'(faultIrq), 32'(expIrq()));
    wr(5'd0, 32'h0000_8000, "R8 ctrl write no effect on flag");
    rd(5'd4, "R8 flag held");
    busOp(1'b1, 5'd5, 32'h0000_0040, 3'b001, "R8 clear with event");
    rd(5'd4, "R8 flag survives clear");
    wr(5'd5, 32'h0000_0040, "R8 clear");
    rd(5'd4, "R8 flag cleared");
    busOp(1'b0, 5'd0, 32'h0, 3'b110, "R8 underrun+frame events");
    rd(5'd4, "R8 underrun+frame set");
    chk(faultIrq === expIrq(), "R9 irq two flags", 32'(faultIrq), 32'(expIrq()));
    wr(5'd17, 32'h0000_1400, "R9 disable two enables");
    chk(faultIrq === expIrq(), "R9 irq masked", 32'(faultIrq), 32'(expIrq()));
    wr(5'd7, 32'h0000_1100, "R5 status invert");
    rd(5'd4, "R5 status after invert");

    rd(5'd8, "R10 data read nonempty");
    rxEmpty = 1'b1;
    rd(5'd8, "R10 data read empty");
    wr(5'd8, 32'h1234_5678, "R11 data write");

    wr(5'd9, 32'hFFFF_FFFF, "R12 reserved 9");
    wr(5'd13, 32'hFFFF_FFFF, "R12 reserved 13");
    wr(5'd22, 32'hFFFF_FFFF, "R12 reserved 22");
    rd(5'd0, "R12 ctrl unchanged");
    rd(5'd16, "R12 ctrl2 unchanged");
    rd(5'd12, "R12 baud unchanged");
    rd(5'd11, "R12 reserved read");
    rd(5'd31, "R12 reserved read high");

    repeat (3) @(negedge clk);
    chk(expData.size() == 0, "R2 responses outstanding", 32'(expData.size()), 0);
    finishRun();
  end

endmodule